// File: doc/BRIEF.md
# Capture Compare PWM Unit

This unit sits beside a free-running timer and a PWM time base and performs one of three jobs, chosen by a 4-bit mode field in its control byte. In capture modes it watches a synchronised pin input and copies the timer into its 16-bit data register when a chosen edge arrives. A prescaler lets a capture happen on every edge, every 4th rising edge or every 16th rising edge. In compare modes it watches for the timer to equal the data register. On a match it toggles, sets or clears the pin, or only raises the flag, or also sends out a one-cycle special-event trigger. In PWM modes it builds a 10-bit duty value from the low data byte and two control bits, and drives a pulse that is synchronous to the external period strobe.

Software reaches the unit through a plain byte write/read port that holds three registers: the control byte, the low data byte and the high data byte. The interrupt flag stays set until the `flag_clear` input is asserted. The unit has no streaming data path, so no port uses valid/ready. Every port is a plain control or status signal, sampled on each clock edge.

Top module: `ccp_unit`

## Requirements
- R1: After reset the control byte, the data register, `pin_out`, `irq_flag` and `special_trig` are all zero.
- R2: Register addresses are: `wr_sel`/`rd_sel` 0 for the control byte, 1 for data bits 7:0, 2 for data bits 15:8. Address 3 reads as zero. Control bits 7:6 read as zero. Bits 5:4 hold the two low duty bits and bits 3:0 hold the mode.
- R3: Modes 0000, 0001 and 0011 disable the unit. `pin_out` is low, the prescaler and the compare pin latch are cleared, and no pin edge or timer match sets the flag or changes the data register.
- R4: Mode 0100 captures on a falling pin edge and mode 0101 captures on a rising pin edge. The timer value sampled at the clock edge that sees the pin change is written to the data register, and `irq_flag` is set at that same edge.
- R5: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. Any write to the control byte clears the edge count.
- R6: Mode 0010 inverts the pin on each compare match and sets the flag.
- R7: Writing mode 1000 drives the pin low and a match then forces it high. Writing mode 1001 drives the pin high and a match then forces it low. Both set the flag.
- R8: Mode 1010 sets only the flag on a match and leaves the pin as it was. Mode 1011 also pulses `special_trig` high for exactly one cycle per match.
- R9: A match is the first cycle on which `timer_val` equals the data register. Further cycles with the values still equal cause no further action.
- R10: Modes 11xx select PWM, with duty = {data[7:0], ctrl[5:4]}. The duty is copied into a shadow register on each `pwm_period_hit`. The pin goes high on that strobe and low on the first edge where `pwm_count` equals the shadow duty. Duty writes made mid-period have no effect until the next strobe.
- R11: A duty of zero keeps the PWM pin low. A duty at or above the period keeps it high for the whole period.
- R12: `irq_flag` stays set until `flag_clear` is high on a clock edge. A capture or match on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_val | input | 16 | Free-running timer value |
| pwm_count | input | 10 | PWM time-base count |
| pwm_period_hit | input | 1 | High for one cycle when the time base reaches its period |
| pin_in | input | 1 | Synchronised external pin level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register address for a write |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 2 | Register address for a read |
| rd_data | output | 8 | Combinational read data |
| flag_clear | input | 1 | Clears the interrupt flag |
| pin_out | output | 1 | Pin drive |
| irq_flag | output | 1 | Sticky interrupt flag |
| special_trig | output | 1 | One-cycle special-event trigger |

## Verification
The assertions assume that `pin_in` has already been synchronised to `clk`. They also assume that `pwm_period_hit` arrives as the time base reaches its period, with the count wrapping to zero on the next cycle. A control write on the same edge as a pin edge is taken to mean the edge belongs to the old mode. The stimulus changes the pin and the timer only between clock edges and holds each pin level for at least one cycle. It drives the PWM count as a clean 0..period ramp with the strobe at the top, and it holds the count steady while it writes registers during a period.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  localparam logic [3:0] MODE_OFF      = 4'b0000;
  localparam logic [3:0] MODE_CMP_TOG  = 4'b0010;
  localparam logic [3:0] MODE_CAP_FALL = 4'b0100;
  localparam logic [3:0] MODE_CAP_RISE = 4'b0101;
  localparam logic [3:0] MODE_CAP_4    = 4'b0110;
  localparam logic [3:0] MODE_CAP_16   = 4'b0111;
  localparam logic [3:0] MODE_CMP_SET  = 4'b1000;
  localparam logic [3:0] MODE_CMP_CLR  = 4'b1001;
  localparam logic [3:0] MODE_CMP_FLAG = 4'b1010;
  localparam logic [3:0] MODE_CMP_TRIG = 4'b1011;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DLO  = 2'd1;
  localparam logic [1:0] SEL_DHI  = 2'd2;

  typedef enum logic [1:0] {FN_OFF, FN_CAP, FN_CMP, FN_PWM} fn_e;

  function automatic fn_e decode_mode(logic [3:0] m);
    fn_e f;
    if (m[3:2] == 2'b11)                          f = FN_PWM;
    else if (m[3:2] == 2'b10 || m == MODE_CMP_TOG) f = FN_CMP;
    else if (m[3:2] == 2'b01)                     f = FN_CAP;
    else                                          f = FN_OFF;
    return f;
  endfunction

endpackage

// File: rtl/ccp_capture.sv
module ccp_capture
  import ccp_pkg::*;
#(
  parameter int DIV_HI = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode,
  input  logic       mode_wr,
  input  logic       pin_in,
  output logic       cap_fire
);
  localparam int PRE_W = $clog2(DIV_HI);

  logic             pin_d;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] limit;
  logic             ev;
  logic             rise, fall;

  assign rise = ~pin_d & pin_in;
  assign fall = pin_d & ~pin_in;

  always_comb begin
    ev    = 1'b0;
    limit = '0;
    case (mode)
      MODE_CAP_FALL: ev = fall;
      MODE_CAP_RISE: ev = rise;
      MODE_CAP_4:    begin ev = rise; limit = PRE_W'(3); end
      MODE_CAP_16:   begin ev = rise; limit = PRE_W'(DIV_HI - 1); end
      default:       ev = 1'b0;
    endcase
  end

  assign cap_fire = ev && (pre_cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_d   <= 1'b0;
      pre_cnt <= '0;
    end else begin
      pin_d <= pin_in;
      if (mode_wr || decode_mode(mode) != FN_CAP) pre_cnt <= '0;
      else if (ev) pre_cnt <= cap_fire ? '0 : pre_cnt + 1'b1;
    end
  end

  p_prescale_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (pre_cnt == '0));

  p_prescale_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CAP_4) |-> (pre_cnt <= PRE_W'(3)));

endmodule

// File: rtl/ccp_compare.sv
module ccp_compare
  import ccp_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode,
  input  logic          mode_wr,
  input  logic [3:0]    new_mode,
  input  logic [TW-1:0] timer_val,
  input  logic [TW-1:0] ref_val,
  output logic          cmp_hit,
  output logic          latch_q,
  output logic          trig_q
);
  logic match, matched_d;

  assign match   = (timer_val == ref_val);
  assign cmp_hit = match && !matched_d && (decode_mode(mode) == FN_CMP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      matched_d <= 1'b0;
      latch_q   <= 1'b0;
      trig_q    <= 1'b0;
    end else begin
      matched_d <= match;
      trig_q    <= cmp_hit && (mode == MODE_CMP_TRIG);
      if (decode_mode(mode) == FN_OFF && !mode_wr)        latch_q <= 1'b0;
      else if (mode_wr && new_mode == MODE_CMP_SET)       latch_q <= 1'b0;
      else if (mode_wr && new_mode == MODE_CMP_CLR)       latch_q <= 1'b1;
      else if (mode_wr && decode_mode(new_mode) == FN_OFF) latch_q <= 1'b0;
      else if (cmp_hit) begin
        case (mode)
          MODE_CMP_TOG: latch_q <= ~latch_q;
          MODE_CMP_SET: latch_q <= 1'b1;
          MODE_CMP_CLR: latch_q <= 1'b0;
          default:      latch_q <= latch_q;
        endcase
      end
    end
  end

  p_trig_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q);

  p_match_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> !cmp_hit);

  p_flag_mode_keeps_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && mode == MODE_CMP_FLAG && !mode_wr) |=> $stable(latch_q));

endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          strobe,
  input  logic [DW-1:0] count,
  input  logic [DW-1:0] duty_in,
  output logic          pwm_q
);
  logic [DW-1:0] shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      pwm_q  <= 1'b0;
    end else if (!enable) begin
      pwm_q <= 1'b0;
    end else if (strobe) begin
      shadow <= duty_in;
      pwm_q  <= (duty_in != '0);
    end else if (count == shadow) begin
      pwm_q <= 1'b0;
    end
  end

  p_zero_duty_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && strobe && duty_in == '0) |=> !pwm_q);

  p_high_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && strobe && duty_in != '0) |=> pwm_q);

  p_no_rise_midperiod_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe) |=> !$rose(pwm_q));

endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
#(
  parameter int TW     = 16,
  parameter int DUTY_W = 10,
  parameter int DIV_HI = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     timer_val,
  input  logic [DUTY_W-1:0] pwm_count,
  input  logic              pwm_period_hit,
  input  logic              pin_in,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        rd_sel,
  output logic [7:0]        rd_data,
  input  logic              flag_clear,
  output logic              pin_out,
  output logic              irq_flag,
  output logic              special_trig
);
  localparam int LOW_W  = DUTY_W - 8;
  localparam int CTRL_W = LOW_W + 4;
  localparam int HI_W   = TW - 8;

  logic [CTRL_W-1:0] ctrl_q;
  logic [TW-1:0]     data_q;
  logic              flag_q;
  logic [3:0]        mode;
  logic              mode_wr;
  logic              cap_fire, cmp_hit, latch_q, trig_q, pwm_q;
  fn_e               fn;

  assign mode    = ctrl_q[3:0];
  assign fn      = decode_mode(mode);
  assign mode_wr = wr_en && (wr_sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (mode_wr) ctrl_q <= wr_data[CTRL_W-1:0];
      if (cap_fire) data_q <= timer_val;
      else if (wr_en && wr_sel == SEL_DLO) data_q[7:0]    <= wr_data;
      else if (wr_en && wr_sel == SEL_DHI) data_q[TW-1:8] <= wr_data[HI_W-1:0];
      if (cap_fire || cmp_hit) flag_q <= 1'b1;
      else if (flag_clear)     flag_q <= 1'b0;
    end
  end

  ccp_capture #(.DIV_HI(DIV_HI)) u_cap (
    .clk(clk), .rst_n(rst_n), .mode(mode), .mode_wr(mode_wr),
    .pin_in(pin_in), .cap_fire(cap_fire)
  );

  ccp_compare #(.TW(TW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .mode(mode), .mode_wr(mode_wr),
    .new_mode(wr_data[3:0]), .timer_val(timer_val), .ref_val(data_q),
    .cmp_hit(cmp_hit), .latch_q(latch_q), .trig_q(trig_q)
  );

  ccp_pwm #(.DW(DUTY_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .enable(fn == FN_PWM),
    .strobe(pwm_period_hit), .count(pwm_count),
    .duty_in({data_q[7:0], ctrl_q[CTRL_W-1:4]}), .pwm_q(pwm_q)
  );

  always_comb begin
    case (fn)
      FN_PWM:  pin_out = pwm_q;
      FN_CMP:  pin_out = latch_q;
      default: pin_out = 1'b0;
    endcase
  end

  always_comb begin
    case (rd_sel)
      SEL_CTRL: rd_data = 8'(ctrl_q);
      SEL_DLO:  rd_data = data_q[7:0];
      SEL_DHI:  rd_data = 8'(data_q[TW-1:8]);
      default:  rd_data = 8'h00;
    endcase
  end

  assign irq_flag     = flag_q;
  assign special_trig = trig_q;

  p_capture_loads_timer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (data_q == $past(timer_val)));

  p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clear) |=> flag_q);

  p_event_sets_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire || cmp_hit) |=> flag_q);

  p_off_pin_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_OFF) |-> !pin_out);

  p_off_no_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_OFF && !flag_q && !mode_wr) |=> !flag_q);

endmodule

// File: tb/tb_ccp_unit.sv
`timescale 1ns/1ps
module tb_ccp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] timer_val = '0;
  logic [9:0]  pwm_count = '0;
  logic        pwm_period_hit = 1'b0;
  logic        pin_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [7:0]  rd_data;
  logic        flag_clear = 1'b0;
  logic        pin_out, irq_flag, special_trig;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ccp_unit dut (
    .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .pwm_count(pwm_count),
    .pwm_period_hit(pwm_period_hit), .pin_in(pin_in), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .flag_clear(flag_clear), .pin_out(pin_out), .irq_flag(irq_flag),
    .special_trig(special_trig)
  );

  // {mode[3:0], pin after mode write, pin after match, trigger pulse}
  localparam logic [6:0] CMP_VEC [5] = '{7'h12, 7'h42, 7'h4C, 7'h50, 7'h59};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    tick;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    rd_sel = s; #0.5; d = rd_data;
  endtask

  task automatic clr_flag;
    flag_clear = 1'b1; tick; flag_clear = 1'b0;
  endtask

  task automatic set_data(input logic [15:0] v);
    wr(2'd1, v[7:0]); wr(2'd2, v[15:8]);
  endtask

  task automatic rise_pulse(input logic [15:0] t);
    timer_val = t; pin_in = 1'b1; tick; pin_in = 1'b0; tick;
  endtask

  task automatic pwm_run(input int duty, input int per, output int highs);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'(duty >> 2));
    wr(2'd0, {2'b00, 2'(duty), 4'hC});
    highs = 0;
    for (int j = 0; j <= per; j++) begin
      pwm_count = (j == 0) ? 10'(per) : 10'(j - 1);
      pwm_period_hit = (j == 0);
      tick;
      if (pin_out) highs++;
    end
    pwm_period_hit = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    int h, exp_h;
    logic [15:0] v16;

    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    // R1 reset state
    rd(2'd0, b); chk(b == 8'h00, "R1 ctrl", b, 0);
    rd(2'd1, b); chk(b == 8'h00, "R1 data lo", b, 0);
    rd(2'd2, b); chk(b == 8'h00, "R1 data hi", b, 0);
    chk({pin_out, irq_flag, special_trig} == 3'b000, "R1 outputs",
        {pin_out, irq_flag, special_trig}, 0);

    // R2 register readback
    wr(2'd0, 8'hFF);
    rd(2'd0, b); chk(b == 8'h3F, "R2 ctrl unimplemented bits", b, 8'h3F);
    wr(2'd0, 8'h00);
    set_data(16'h5AA5);
    rd(2'd1, b); chk(b == 8'hA5, "R2 data lo", b, 8'hA5);
    rd(2'd2, b); chk(b == 8'h5A, "R2 data hi", b, 8'h5A);
    rd(2'd3, b); chk(b == 8'h00, "R2 unused address", b, 0);

    // R3 reserved/off modes ignore pin edges and matches
    set_data(16'h0055);
    clr_flag;
    wr(2'd0, 8'h03);
    timer_val = 16'h0055; tick;
    rise_pulse(16'h0077);
    wr(2'd0, 8'h01);
    timer_val = 16'h0000; tick; timer_val = 16'h0055; tick;
    rise_pulse(16'h0088);
    chk(!irq_flag, "R3 no flag when disabled", irq_flag, 0);
    chk(!pin_out, "R3 pin low when disabled", pin_out, 0);
    rd(2'd1, b); chk(b == 8'h55, "R3 data untouched", b, 8'h55);

    // R4 single-edge capture
    wr(2'd0, 8'h00); set_data(16'h0000); clr_flag;
    wr(2'd0, 8'h05);
    timer_val = 16'h00AA; pin_in = 1'b1; tick;
    rd(2'd1, b); chk(b == 8'hAA, "R4 rising capture", b, 8'hAA);
    chk(irq_flag, "R4 flag on rising capture", irq_flag, 1);
    clr_flag;
    wr(2'd0, 8'h04);
    timer_val = 16'h0BB0; pin_in = 1'b0; tick;
    rd(2'd2, b); chk(b == 8'h0B, "R4 falling capture", b, 8'h0B);
    chk(irq_flag, "R4 flag on falling capture", irq_flag, 1);

    // R5 prescaled capture
    wr(2'd0, 8'h00); set_data(16'h0000); clr_flag;
    wr(2'd0, 8'h06);
    for (int i = 1; i <= 3; i++) rise_pulse(16'(i));
    chk(!irq_flag, "R5 no capture before 4th edge", irq_flag, 0);
    rise_pulse(16'h0004);
    rd(2'd1, b); chk(b == 8'h04 && irq_flag, "R5 capture on 4th edge", b, 4);
    clr_flag;
    rise_pulse(16'h0011); rise_pulse(16'h0012);
    wr(2'd0, 8'h06);
    for (int i = 0; i < 3; i++) rise_pulse(16'h0020);
    rd(2'd1, b); chk(b == 8'h04 && !irq_flag, "R5 count cleared by ctrl write", b, 4);
    rise_pulse(16'h0099);
    rd(2'd1, b); chk(b == 8'h99, "R5 capture after restart", b, 8'h99);
    wr(2'd0, 8'h07); clr_flag;
    for (int i = 0; i < 15; i++) rise_pulse(16'(16'h0100 + i));
    rd(2'd1, b); chk(b == 8'h99 && !irq_flag, "R5 no capture before 16th edge", b, 8'h99);
    rise_pulse(16'h0200);
    rd(2'd2, b); chk(b == 8'h02, "R5 capture on 16th edge", b, 2);

    // R6 R7 R8 R9 compare table
    foreach (CMP_VEC[k]) begin
      wr(2'd0, 8'h00); timer_val = 16'h0000; clr_flag;
      set_data(16'h1234);
      wr(2'd0, {4'h0, CMP_VEC[k][6:3]});
      chk(pin_out == CMP_VEC[k][2], "R7 pin on mode entry", pin_out, CMP_VEC[k][2]);
      timer_val = 16'h1234; tick;
      chk(pin_out == CMP_VEC[k][1], "R6/R7/R8 pin after match", pin_out, CMP_VEC[k][1]);
      chk(irq_flag, "R6/R7/R8 flag on match", irq_flag, 1);
      chk(special_trig == CMP_VEC[k][0], "R8 trigger on match", special_trig, CMP_VEC[k][0]);
      tick;
      chk(!special_trig, "R8 trigger one cycle", special_trig, 0);
      chk(pin_out == CMP_VEC[k][1], "R9 no repeat while equal", pin_out, CMP_VEC[k][1]);
    end
    // R6 second toggle in a new equal interval
    wr(2'd0, 8'h00); timer_val = 16'h0000; wr(2'd0, 8'h02);
    timer_val = 16'h1234; tick; timer_val = 16'h0001; tick;
    timer_val = 16'h1234; tick;
    chk(!pin_out, "R6 toggle back", pin_out, 0);

    // R12 sticky flag and clear
    repeat (3) tick;
    chk(irq_flag, "R12 flag sticky", irq_flag, 1);
    clr_flag;
    chk(!irq_flag, "R12 flag cleared", irq_flag, 0);

    // R10 R11 PWM duty
    wr(2'd0, 8'h00); timer_val = 16'h0000;
    for (int d = 0; d < 4; d++) begin
      int duty;
      duty = (d == 0) ? 0 : (d == 1) ? 5 : (d == 2) ? 13 : 25;
      pwm_run(duty, 20, h);
      exp_h = (duty == 0) ? 0 : (duty >= 20) ? 21 : duty + 1;
      chk(h == exp_h, (duty == 0 || duty >= 20) ? "R11 duty extreme" : "R10 duty width", h, exp_h);
    end

    // R10 shadow holds old duty across mid-period write
    pwm_run(5, 1, h);
    pwm_count = 10'd1;
    wr(2'd1, 8'h3F);
    chk(pin_out, "R10 high before old duty", pin_out, 1);
    for (int c = 2; c <= 5; c++) begin pwm_count = 10'(c); tick; end
    chk(!pin_out, "R10 shadow duty used", pin_out, 0);
    for (int c = 6; c <= 12; c++) begin pwm_count = 10'(c); tick; end
    chk(!pin_out, "R10 stays low until strobe", pin_out, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule